// File: doc/BRIEF.md
# Bus Address Widening and Narrowing Remapper

This block sits in programmable logic between a root port with a 32-bit address space and a CPU complex with a 64-bit address space. It works only on address channels, either the read or the write address channel, with valid/ready handshakes. Data channels do not pass through it.

In the inbound direction, a narrow intermediate address from the root port becomes a wide CPU address. The block subtracts the base of the active window from the narrow address and adds a configured 64-bit CPU base. The window depends on a mode select that is static in normal use:

- In coherent mode the window covers the whole 4 GiB narrow space, starting at zero.
- In non-coherent mode the window is the upper 2 GiB, starting at 0x8000_0000.

A non-coherent address below the window is forwarded unchanged and sets a sticky error flag.

In the outbound direction, a wide CPU address is split. The low 32 bits go to the root port. The upper 32 bits are held in the fabric beside the beat. Each direction has one register stage.

Top module: `addr_widen_remap`

## Requirements
- R1: After reset, `in_out_valid`, `ob_out_valid` and `win_err` are 0, and `in_ready` and `ob_ready` are 1.
- R2: When `cfg_noncoh`=0 (coherent), an accepted inbound address A appears as `in_out_addr` = `cfg_cpu_base` + A, modulo 2^64. `win_err` is not set by any address.
- R3: When `cfg_noncoh`=1 and A >= 0x8000_0000, `in_out_addr` = `cfg_cpu_base` + (A - 0x8000_0000), modulo 2^64.
- R4: When `cfg_noncoh`=1 and A < 0x8000_0000, `in_out_addr` is A zero-extended to 64 bits. `win_err` reads 1 from the cycle after acceptance and stays 1 until reset.
- R5: An accepted outbound address W appears as `ob_out_addr` = W[31:0] and `ob_hi` = W[63:32]. `ob_hi` keeps that value until another outbound beat is accepted.
- R6: Each direction has one cycle of latency. A beat accepted at a clock edge is valid after that edge. The input ready is `!out_valid || out_ready`. A stalled output keeps its address stable. No beat is lost or duplicated when a new beat is accepted at the same edge as the held one leaves.
- R7: The block captures `cfg_noncoh` and `cfg_cpu_base` only at an edge where the inbound stage holds no beat and accepts none. Beats accepted while the stage is busy use the earlier configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_noncoh | input | 1 | Window mode: 0 coherent, 1 non-coherent |
| cfg_cpu_base | input | 64 | CPU base address that the inbound window maps onto |
| in_valid | input | 1 | Inbound narrow address valid |
| in_ready | output | 1 | Inbound narrow address ready |
| in_addr | input | 32 | Inbound narrow intermediate address |
| in_out_valid | output | 1 | Inbound wide address valid |
| in_out_ready | input | 1 | Inbound wide address ready |
| in_out_addr | output | 64 | Inbound wide CPU address |
| win_err | output | 1 | Sticky out-of-window flag |
| ob_valid | input | 1 | Outbound wide address valid |
| ob_ready | output | 1 | Outbound wide address ready |
| ob_addr | input | 64 | Outbound wide CPU address |
| ob_out_valid | output | 1 | Outbound narrow address valid |
| ob_out_ready | input | 1 | Outbound narrow address ready |
| ob_out_addr | output | 32 | Outbound narrow address |
| ob_hi | output | 32 | Upper address half held in the fabric |

## Verification
A captured configuration that is wrong, or that changes while a beat is in flight, shows in `in_out_addr` on the first beat accepted afterwards. That is one cycle after the handshake. The bench therefore changes the mode while a beat is stalled and checks the beat that follows it. A wrong stage state shows at once as a changed address during a stall, or as a missing or doubled beat when accept and release fall on the same edge. An error flag that does not stick shows on `win_err` in the next cycle.

// File: rtl/remap_pkg.sv
package remap_pkg;
   localparam int unsigned NARROW_W_DEF = 32;
   localparam int unsigned WIDE_W_DEF   = 64;

   typedef enum logic {
      MODE_COH    = 1'b0,
      MODE_NONCOH = 1'b1
   } win_mode_e;
endpackage

// File: rtl/rs_stage.sv
module rs_stage #(
   parameter int unsigned W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid_i,
   output logic         ready_o,
   input  logic [W-1:0] data_i,
   output logic         valid_o,
   input  logic         ready_i,
   output logic [W-1:0] data_o
);
   if (W < 1) begin : g_bad_w
      $error("rs_stage: W must be at least 1");
   end

   logic         vld_q;
   logic [W-1:0] dat_q;
   logic         take;

   assign ready_o = !vld_q || ready_i;
   assign take    = valid_i && ready_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else begin
         if (take)         vld_q <= 1'b1;
         else if (ready_i) vld_q <= 1'b0;
         if (take)         dat_q <= data_i;
      end
   end

   assign valid_o = vld_q;
   assign data_o  = dat_q;

   // R6: a stalled beat neither vanishes nor changes
   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o && $stable(data_o));

   // R6: an accepted beat is presented after the next edge
   p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && ready_o |=> valid_o && (data_o == $past(data_i)));
endmodule

// File: rtl/inb_xlate.sv
module inb_xlate
   import remap_pkg::*;
#(
   parameter int unsigned        NARROW_W    = NARROW_W_DEF,
   parameter int unsigned        WIDE_W      = WIDE_W_DEF,
   parameter logic [NARROW_W-1:0] NC_WIN_BASE = NARROW_W'(1) << (NARROW_W-1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_noncoh_i,
   input  logic [WIDE_W-1:0]   cfg_base_i,
   input  logic                load_en,
   input  logic                accept,
   input  logic [NARROW_W-1:0] addr_i,
   output logic [WIDE_W-1:0]   addr_o,
   output logic                err_o
);
   win_mode_e            mode_q;
   logic [WIDE_W-1:0]    base_q;
   logic [NARROW_W-1:0]  win_lo;
   logic [NARROW_W-1:0]  offs;
   logic                 in_win;
   logic                 err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_COH;
         base_q <= '0;
      end else if (load_en) begin
         mode_q <= win_mode_e'(cfg_noncoh_i);
         base_q <= cfg_base_i;
      end
   end

   always_comb begin
      win_lo = (mode_q == MODE_NONCOH) ? NC_WIN_BASE : '0;
      in_win = (addr_i >= win_lo);
      offs   = addr_i - win_lo;
      addr_o = in_win ? (base_q + WIDE_W'(offs)) : WIDE_W'(addr_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                err_q <= 1'b0;
      else if (accept && !in_win) err_q <= 1'b1;
   end
   assign err_o = err_q;

   // R4: the error flag never clears without reset
   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R4: a non-coherent beat below the window raises the flag
   p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (mode_q == MODE_NONCOH) && (addr_i < NC_WIN_BASE) |=> err_o);

   // R7: configuration is frozen while the stage is busy
   p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(base_q) && $stable(mode_q));
endmodule

// File: rtl/addr_widen_remap.sv
module addr_widen_remap
   import remap_pkg::*;
#(
   parameter int unsigned NARROW_W = NARROW_W_DEF,
   parameter int unsigned WIDE_W   = WIDE_W_DEF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_noncoh,
   input  logic [WIDE_W-1:0]     cfg_cpu_base,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [NARROW_W-1:0]   in_addr,
   output logic                  in_out_valid,
   input  logic                  in_out_ready,
   output logic [WIDE_W-1:0]     in_out_addr,
   output logic                  win_err,
   input  logic                  ob_valid,
   output logic                  ob_ready,
   input  logic [WIDE_W-1:0]     ob_addr,
   output logic                  ob_out_valid,
   input  logic                  ob_out_ready,
   output logic [NARROW_W-1:0]   ob_out_addr,
   output logic [WIDE_W-NARROW_W-1:0] ob_hi
);
   localparam int unsigned HI_W = WIDE_W - NARROW_W;

   if (NARROW_W < 2) begin : g_bad_narrow
      $error("addr_widen_remap: NARROW_W must be at least 2");
   end
   if (WIDE_W <= NARROW_W) begin : g_bad_wide
      $error("addr_widen_remap: WIDE_W must exceed NARROW_W");
   end

   logic              in_acc;
   logic              cfg_load;
   logic [WIDE_W-1:0] wide_xl;
   logic [WIDE_W-1:0] ob_q;

   assign in_acc   = in_valid && in_ready;
   assign cfg_load = !in_out_valid && !in_acc;

   inb_xlate #(
      .NARROW_W(NARROW_W),
      .WIDE_W  (WIDE_W)
   ) u_xl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_noncoh_i(cfg_noncoh),
      .cfg_base_i  (cfg_cpu_base),
      .load_en     (cfg_load),
      .accept      (in_acc),
      .addr_i      (in_addr),
      .addr_o      (wide_xl),
      .err_o       (win_err)
   );

   rs_stage #(.W(WIDE_W)) u_in_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid_i(in_valid),
      .ready_o(in_ready),
      .data_i (wide_xl),
      .valid_o(in_out_valid),
      .ready_i(in_out_ready),
      .data_o (in_out_addr)
   );

   rs_stage #(.W(WIDE_W)) u_ob_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid_i(ob_valid),
      .ready_o(ob_ready),
      .data_i (ob_addr),
      .valid_o(ob_out_valid),
      .ready_i(ob_out_ready),
      .data_o (ob_q)
   );

   assign ob_out_addr = ob_q[NARROW_W-1:0];
   assign ob_hi       = ob_q[WIDE_W-1:NARROW_W];

   // R5: the held upper half only moves when a new outbound beat is taken
   p_hi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ob_valid && ob_ready) |=> $stable(ob_hi));

   // R6: inbound ready follows the stage occupancy and the sink
   p_in_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_out_valid && !in_out_ready |-> !in_ready);

   initial begin
      assert (HI_W >= 1) else $error("addr_widen_remap: empty upper half");
   end
endmodule

// File: tb/addr_widen_remap_test.sv
module addr_widen_remap_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_noncoh = 1'b0;
   logic [63:0] cfg_cpu_base = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_addr = '0;
   logic        in_out_valid;
   logic        in_out_ready = 1'b1;
   logic [63:0] in_out_addr;
   logic        win_err;
   logic        ob_valid = 1'b0;
   logic        ob_ready;
   logic [63:0] ob_addr = '0;
   logic        ob_out_valid;
   logic        ob_out_ready = 1'b1;
   logic [31:0] ob_out_addr;
   logic [31:0] ob_hi;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   addr_widen_remap uut (
      .clk(clk), .rst_n(rst_n), .cfg_noncoh(cfg_noncoh), .cfg_cpu_base(cfg_cpu_base),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .in_out_valid(in_out_valid), .in_out_ready(in_out_ready), .in_out_addr(in_out_addr),
      .win_err(win_err), .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_addr(ob_addr),
      .ob_out_valid(ob_out_valid), .ob_out_ready(ob_out_ready), .ob_out_addr(ob_out_addr),
      .ob_hi(ob_hi)
   );

   // vector: {noncoh, base[63:0], narrow addr[31:0], expected wide[63:0]}
   localparam int NV = 7;
   localparam logic [160:0] VEC [NV] = '{
      {1'b0, 64'h0000_0010_0000_0000, 32'h0000_0000, 64'h0000_0010_0000_0000},
      {1'b0, 64'h0000_0010_0000_0000, 32'hFFFF_FFFF, 64'h0000_0010_FFFF_FFFF},
      {1'b1, 64'h0000_0010_0000_0000, 32'h8000_0000, 64'h0000_0010_0000_0000},
      {1'b1, 64'h0000_0010_0000_0000, 32'hFFFF_FFFF, 64'h0000_0010_7FFF_FFFF},
      {1'b0, 64'h0000_0001_2345_6000, 32'h0000_1000, 64'h0000_0001_2345_7000},
      {1'b1, 64'hFFFF_FFFF_C000_0000, 32'hC000_0000, 64'h0000_0000_0000_0000},
      {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0001, 64'h0000_0000_0000_0000}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // drive one inbound beat for one edge (stage assumed free)
   task automatic send_in(input logic [31:0] a);
      in_valid = 1'b1;
      in_addr  = a;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic set_cfg(input logic nc, input logic [63:0] b);
      cfg_noncoh   = nc;
      cfg_cpu_base = b;
      idle(2);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      idle(3);
      // R1: reset state
      chk("R1 in_out_valid", 64'(in_out_valid), 64'd0);
      chk("R1 ob_out_valid", 64'(ob_out_valid), 64'd0);
      chk("R1 win_err",      64'(win_err),      64'd0);
      chk("R1 ready",        64'({in_ready, ob_ready}), 64'd3);
      rst_n = 1'b1;
      idle(1);

      // R2 / R3: table walk
      for (int v = 0; v < NV; v++) begin
         set_cfg(VEC[v][160], VEC[v][159:96]);
         send_in(VEC[v][95:64]);
         chk(VEC[v][160] ? "R3 vector valid" : "R2 vector valid", 64'(in_out_valid), 64'd1);
         chk(VEC[v][160] ? "R3 vector addr" : "R2 vector addr", in_out_addr, VEC[v][63:0]);
         chk("R2 no error in window", 64'(win_err), 64'd0);
         idle(1);
      end

      // R6: backpressure, no loss or duplication
      set_cfg(1'b0, 64'h0000_0020_0000_0000);
      in_out_ready = 1'b0;
      send_in(32'h0000_0100);
      in_valid = 1'b1;
      in_addr  = 32'h0000_0200;
      idle(3);
      chk("R6 stall ready low", 64'(in_ready), 64'd0);
      chk("R6 stall addr held", in_out_addr, 64'h0000_0020_0000_0100);
      // R7: change config while busy; the waiting beat keeps the old mode
      cfg_noncoh   = 1'b1;
      cfg_cpu_base = 64'h0000_0030_0000_0000;
      idle(2);
      in_out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R6 second beat valid", 64'(in_out_valid), 64'd1);
      chk("R7 busy beat uses old config", in_out_addr, 64'h0000_0020_0000_0200);
      @(negedge clk);
      chk("R6 no duplicate", 64'(in_out_valid), 64'd0);
      idle(1);
      send_in(32'h8000_0040);
      chk("R7 new config after idle", in_out_addr, 64'h0000_0030_0000_0040);
      idle(1);

      // R4: out-of-window in non-coherent mode
      chk("R4 flag clear before", 64'(win_err), 64'd0);
      send_in(32'h7FFF_FFF0);
      chk("R4 passthrough addr", in_out_addr, 64'h0000_0000_7FFF_FFF0);
      chk("R4 flag set", 64'(win_err), 64'd1);
      idle(1);
      send_in(32'h8000_0000);
      chk("R4 flag sticks", 64'(win_err), 64'd1);
      set_cfg(1'b0, 64'd0);
      chk("R4 flag sticks across mode", 64'(win_err), 64'd1);

      // R5: outbound split and hold
      ob_valid = 1'b1;
      ob_addr  = 64'h1234_5678_9ABC_DEF0;
      @(negedge clk);
      ob_valid = 1'b0;
      ob_addr  = 64'hFFFF_FFFF_FFFF_FFFF;
      chk("R5 narrow addr", 64'(ob_out_addr), 64'h9ABC_DEF0);
      chk("R5 upper half", 64'(ob_hi), 64'h1234_5678);
      idle(3);
      chk("R5 upper held", 64'(ob_hi), 64'h1234_5678);
      chk("R6 outbound drained", 64'(ob_out_valid), 64'd0);
      ob_out_ready = 1'b0;
      ob_valid = 1'b1;
      ob_addr  = 64'hAAAA_0000_5555_1111;
      @(negedge clk);
      ob_addr  = 64'hBBBB_0000_6666_2222;
      idle(2);
      chk("R6 outbound stall addr", 64'(ob_out_addr), 64'h5555_1111);
      chk("R5 outbound stall hi", 64'(ob_hi), 64'hAAAA_0000);
      ob_valid = 1'b0;
      ob_out_ready = 1'b1;
      idle(2);

      // R1: reset clears sticky error
      rst_n = 1'b0;
      idle(2);
      chk("R1 reset clears error", 64'(win_err), 64'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule